// File: doc/BRIEF.md
# Redundant SAR Switching Sequencer

This block is the digital sequencer of a differential charge-redistribution successive-approximation converter that switches around the common-mode level. A sample strobe clears it. After that, it takes one comparator decision on each pulse of a self-timed bit-cycle strobe and turns the decisions into bottom-plate switch controls for both halves of the DAC.

The three most significant decisions are applied together to seven equal segments of 256 units each, as a thermometer pattern. The remaining eleven decisions go one at a time to a redundant lower array. Its weights, from first decided to last, are 112, 64, 32, 20, 10, 8, 4, 2, 2, 1 and 1 units. Because of this redundancy a full conversion takes two more decisions than a plain binary search of the same resolution.

A 2-bit resolution select shortens the conversion so that it gives 12, 11, 10 or 9 bits. The select is also decoded into a 3-bit thermometer enable for the negative-voltage switches. A one-cycle done pulse marks the end of the conversion, and the raw 14-bit decision word is available on `dec_o`.

Top module: `sar_redundant_seq`

## Requirements
- R1: After reset, every switch control is 00 (common mode), `dec_o` is 0, `done_o` is 0 and `res_en_o` is 000.
- R2: While `sample_i` is high, the decision word and every switch control are cleared to 0, `strobe_i` has no effect, and `res_sel_i` is latched.
- R3: After a sample, strobe k (counting from k = 0) stores `cmp_i` into `dec_o[13-k]`. The seven segment controls stay 00 until the third decision has been stored.
- R4: Once three decisions are stored, let u be the 3-bit value {dec_o[13],dec_o[12],dec_o[11]}. Segment j (j = 0..6, field `seg_p_o[2j+1:2j]`) then drives 10 (Vref) when j < u and 01 (GND) otherwise. This gives 0000000 for u=0, 0001111 for u=4 and 1111111 for u=7, with 1 meaning Vref.
- R5: Lower capacitor i (i = 0..10, field `cap_p_o[2i+1:2i]`, where i=0 is the 112-unit capacitor) stays 00 until decision 3+i is stored. It then drives 10 if `dec_o[10-i]` is 1 and 01 if it is 0.
- R6: Every negative-side field (`seg_n_o`, `cap_n_o`) is its positive-side field with the two bits swapped, so that 00 stays 00 and Vref and GND are exchanged.
- R7: The conversion takes 14, 13, 12 or 11 decisions for `res_sel_i` 0, 1, 2 or 3 respectively. The smallest capacitors left unused stay 00, and `res_en_o` is 000, 001, 011 or 111 for those same select values.
- R8: `done_o` is high for exactly one cycle, in the cycle after the final decision is stored. Strobes after that point change nothing until the next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 1 | Sample phase; clears the sequencer and latches the resolution select |
| strobe_i | input | 1 | Bit-cycle strobe; one decision is stored per high cycle |
| cmp_i | input | 1 | Comparator decision (1: positive side higher) |
| res_sel_i | input | 2 | Resolution select: 0=12, 1=11, 2=10, 3=9 bits |
| seg_p_o | output | 14 | Positive-side controls of the 7 segments, 2 bits each |
| seg_n_o | output | 14 | Negative-side controls of the 7 segments |
| cap_p_o | output | 22 | Positive-side controls of the 11 lower capacitors |
| cap_n_o | output | 22 | Negative-side controls of the 11 lower capacitors |
| dec_o | output | 14 | Raw decisions; bit 13 holds the first decision |
| done_o | output | 1 | One-cycle end-of-conversion pulse |
| res_en_o | output | 3 | Thermometer enable for the resolution switches |

## Verification
The bench uses upper codes 0, 4 and 7. A design that decoded the thermometer pattern wrongly, or switched the segments before the third decision, would show the wrong segment pattern at one of those points. It runs the 9-bit and 11-bit modes, where a design that counted the wrong number of cycles would raise done early or late, or would drive the unused small capacitors. Strobes held high during the sample phase, and strobes given after done, catch a design that stores decisions while it should be idle. A sample given in the middle of a conversion checks that all state really returns to common mode.

// File: rtl/sar_redundant_seq.sv
module sar_redundant_seq #(
  parameter int NUPPER = 3,
  parameter int NLOWER = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sample_i,
  input  logic                  strobe_i,
  input  logic                  cmp_i,
  input  logic [1:0]            res_sel_i,
  output logic [2*((1<<NUPPER)-1)-1:0] seg_p_o,
  output logic [2*((1<<NUPPER)-1)-1:0] seg_n_o,
  output logic [2*NLOWER-1:0]   cap_p_o,
  output logic [2*NLOWER-1:0]   cap_n_o,
  output logic [NUPPER+NLOWER-1:0] dec_o,
  output logic                  done_o,
  output logic [2:0]            res_en_o
);
  localparam int NSEG = (1 << NUPPER) - 1;
  localparam int NDEC = NUPPER + NLOWER;
  localparam int CW   = $clog2(NDEC + 1);

  logic [NDEC-1:0] dec_q;
  logic [CW-1:0]   cnt_q, len_q;
  logic [1:0]      res_q;
  logic            busy_q, done_q;
  logic [NUPPER-1:0] ucode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q  <= '0;
      cnt_q  <= '0;
      len_q  <= CW'(NDEC);
      res_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (sample_i) begin
        dec_q  <= '0;
        cnt_q  <= '0;
        busy_q <= 1'b1;
        res_q  <= res_sel_i;
        len_q  <= CW'(NDEC) - CW'(res_sel_i);
      end else if (busy_q && strobe_i) begin
        dec_q[CW'(NDEC-1) - cnt_q] <= cmp_i;
        cnt_q <= cnt_q + CW'(1);
        if (cnt_q == len_q - CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign ucode    = dec_q[NDEC-1 -: NUPPER];
  assign dec_o    = dec_q;
  assign done_o   = done_q;
  assign res_en_o = {res_q == 2'd3, res_q >= 2'd2, res_q >= 2'd1};

  for (genvar j = 0; j < NSEG; j++) begin : g_seg
    logic [1:0] p;
    assign p = (cnt_q >= CW'(NUPPER)) ? ((j < int'(ucode)) ? 2'b10 : 2'b01) : 2'b00;
    assign seg_p_o[2*j +: 2] = p;
    assign seg_n_o[2*j +: 2] = {p[0], p[1]};
  end

  for (genvar i = 0; i < NLOWER; i++) begin : g_cap
    logic [1:0] p;
    assign p = (cnt_q > CW'(NUPPER + i)) ? (dec_q[NLOWER-1-i] ? 2'b10 : 2'b01) : 2'b00;
    assign cap_p_o[2*i +: 2] = p;
    assign cap_n_o[2*i +: 2] = {p[0], p[1]};
  end

  p_sample_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_i |=> (dec_o == '0 && cap_p_o == '0 && seg_p_o == '0));
  p_dec_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_i && !sample_i) |=> $stable(dec_o));
  p_cap_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_i && !sample_i) |=> $stable(cap_p_o));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_after_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(strobe_i) && !$past(sample_i)));
endmodule

// File: tb/sar_redundant_seq_tb_top.sv
module sar_redundant_seq_tb_top;
  logic clk = 0, rst_n = 0, sample = 0, strobe = 0, cmp = 0;
  logic [1:0] sel = 0;
  logic [13:0] seg_p, seg_n, dec;
  logic [21:0] cap_p, cap_n;
  logic done;
  logic [2:0] res_en;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  sar_redundant_seq dut_i (
    .clk(clk), .rst_n(rst_n), .sample_i(sample), .strobe_i(strobe), .cmp_i(cmp),
    .res_sel_i(sel), .seg_p_o(seg_p), .seg_n_o(seg_n), .cap_p_o(cap_p),
    .cap_n_o(cap_n), .dec_o(dec), .done_o(done), .res_en_o(res_en));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] ex_seg(input logic [13:0] d, input int n);
    logic [13:0] r = '0;
    int u = int'(d[13:11]);
    if (n >= 3)
      for (int j = 0; j < 7; j++) r[2*j +: 2] = (j < u) ? 2'b10 : 2'b01;
    return r;
  endfunction

  function automatic logic [21:0] ex_cap(input logic [13:0] d, input int n);
    logic [21:0] r = '0;
    for (int i = 0; i < 11; i++)
      if (n > 3 + i) r[2*i +: 2] = d[10-i] ? 2'b10 : 2'b01;
    return r;
  endfunction

  function automatic logic [21:0] swp(input logic [21:0] v);
    logic [21:0] r;
    for (int i = 0; i < 11; i++) r[2*i +: 2] = {v[2*i], v[2*i+1]};
    return r;
  endfunction

  task automatic do_sample(input logic [1:0] s);
    @(negedge clk); sample = 1; sel = s;
    @(negedge clk); sample = 0;
  endtask

  task automatic pulse(input logic v);
    @(negedge clk); strobe = 1; cmp = v;
    @(negedge clk); strobe = 0;
  endtask

  task automatic t_reset;
    chk("R1 seg", seg_p, 0); chk("R1 cap", cap_p, 0);
    chk("R1 dec", dec, 0); chk("R1 done", done, 0); chk("R1 res_en", res_en, 0);
  endtask

  task automatic t_run(input logic [1:0] s, input logic [13:0] pat);
    int len = 14 - int'(s);
    logic [13:0] exp_d;
    do_sample(s);
    chk("R7 res_en", res_en, (s == 0) ? 0 : (s == 1) ? 3'b001 : (s == 2) ? 3'b011 : 3'b111);
    chk("R2 cleared", dec, 0);
    for (int k = 0; k < len; k++) begin
      pulse(pat[13-k]);
      exp_d = pat & ~(14'h3fff >> (k + 1));
      chk("R3 dec", dec, exp_d);
      chk("R4 seg_p", seg_p, ex_seg(exp_d, k + 1));
      chk("R6 seg_n", seg_n, swp({8'h0, ex_seg(exp_d, k + 1)}));
      chk("R5 cap_p", cap_p, ex_cap(exp_d, k + 1));
      chk("R6 cap_n", cap_n, swp(ex_cap(exp_d, k + 1)));
      chk("R8 R7 done", done, k == len - 1);
    end
    @(negedge clk);
    chk("R8 done one cycle", done, 0);
    exp_d = dec;
    pulse(~pat[0]);
    pulse(1'b1);
    chk("R8 ignored after done dec", dec, pat & ~(14'h3fff >> len));
    chk("R8 ignored after done cap", cap_p, ex_cap(exp_d, len));
    chk("R8 no second done", done, 0);
  endtask

  task automatic t_sample_ignore;
    @(negedge clk); sample = 1; strobe = 1; cmp = 1; sel = 0;
    @(negedge clk); @(negedge clk);
    chk("R2 strobe during sample", dec, 0);
    sample = 0; strobe = 0;
    for (int k = 0; k < 5; k++) pulse(1'b1);
    chk("R3 partial", dec, 14'h3e00);
    do_sample(2'd0);
    chk("R2 resample dec", dec, 0);
    chk("R2 resample seg", seg_p, 0);
    chk("R2 resample cap", cap_p, 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_run(2'd0, 14'b100_10110011010);
    t_run(2'd0, 14'b000_01101100101);
    t_run(2'd3, 14'b111_11001000000);
    t_run(2'd1, 14'b011_00111011100);
    t_sample_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule